// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer with Address-Space Tags

This block caches virtual-to-physical page translations for a processor core. A lookup presents a virtual address, the identifier of the current address space and a read/write flag. All stored entries are compared at once. One clock later the block answers with exactly one of three outcomes: a hit that carries the physical address, a miss, or a protection fault. The physical address is the stored physical page number placed above the untouched page offset.

Each entry is tagged with an address-space identifier. Translations of several processes can therefore stay resident together, and a context switch needs no flush. Each entry also holds a write-permission bit, a use bit that records recent access, and a dirty bit that records that the page has been written. After a miss, the surrounding logic installs the translation through the fill port. The block picks the slot itself: a free slot first, otherwise one whose use bit is clear. Two invalidation inputs clear either everything or only the entries of one address space.

Page-table walking lives outside the block. A miss is only reported.

Top module: `tlb_fa`

## Requirements
- R1: A lookup hits when a valid entry holds the same virtual page number (address bits above the low PAGE_W bits) and the same address-space identifier. The physical address returned is that entry's physical page number concatenated above the lookup's low PAGE_W address bits.
- R2: A lookup presented at one clock edge is answered at the next edge with rsp_valid high and exactly one of rsp_hit, rsp_miss and rsp_fault high. Without a lookup, rsp_valid and all three flags are low.
- R3: An entry whose identifier differs from the lookup's identifier never matches, even when its page number does.
- R4: A write lookup that matches an entry whose write-permission bit is 0 answers with rsp_fault, rsp_paddr of zero and rsp_dirty of zero, and leaves the dirty bit unchanged. A read of that entry still hits.
- R5: A permitted write hit sets the entry's dirty bit. On every hit, rsp_dirty shows the dirty bit including the effect of that same access. A fill clears the dirty bit.
- R6: A fill whose page and identifier match no valid entry goes into the lowest-numbered invalid slot when one exists.
- R7: When every slot is valid, a fill goes into the lowest-numbered slot whose use bit is 0. The use bit is set by every fill and by every lookup that matches the entry, whether it hits or faults.
- R8: If an update would leave every use bit at 1, all use bits are cleared instead.
- R9: A fill whose page and identifier match a valid entry overwrites that entry in place, so no two valid entries ever match one lookup.
- R10: inv_all clears the valid, use and dirty bits of every entry.
- R11: inv_asid_en clears only the entries whose identifier equals inv_asid. All other entries keep their translations.
- R12: A fill in a cycle where either invalidate input is high is dropped.
- R13: A lookup is answered from the contents held before the edge. A fill, use or dirty update, or invalidation in the same cycle affects only later lookups.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is a write access |
| lk_vaddr | input | VA_W | Virtual address of the lookup |
| lk_asid | input | ASID_W | Current address-space identifier |
| fill_en | input | 1 | Install a translation |
| fill_vpn | input | VA_W-PAGE_W | Virtual page number to install |
| fill_asid | input | ASID_W | Identifier of the installed entry |
| fill_ppn | input | PA_W-PAGE_W | Physical page number to install |
| fill_wr_ok | input | 1 | Write permission of the installed entry |
| inv_all | input | 1 | Invalidate every entry |
| inv_asid_en | input | 1 | Invalidate entries of one identifier |
| inv_asid | input | ASID_W | Identifier to invalidate |
| rsp_valid | output | 1 | Answer to last cycle's lookup |
| rsp_hit | output | 1 | Translation found and permitted |
| rsp_miss | output | 1 | No matching entry |
| rsp_fault | output | 1 | Write to a page without write permission |
| rsp_dirty | output | 1 | Dirty bit of the hit entry after this access |
| rsp_paddr | output | PA_W | Translated physical address (zero unless hit) |

## Verification
The bench fills all 128 slots and then forces replacement. It checks that the displaced translation is the lowest slot with a clear use bit after the use bits wrap to zero. A design that keeps stale use bits, or never clears them, would evict a recently used entry, and the next lookup of that entry would miss. It issues write lookups to read-only pages; a design that translates them or marks them dirty would report a hit. It collides a fill with an invalidation and a fill with a lookup of the same page, which exposes designs that let the fill win or answer from the updated contents. A long random phase over a small page space with four identifiers then churns replacement, refill in place, and per-identifier invalidation against a bench model.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

  typedef enum logic [1:0] {
    LK_IDLE  = 2'd0,
    LK_MISS  = 2'd1,
    LK_HIT   = 2'd2,
    LK_FAULT = 2'd3
  } lk_kind_t;

  // Outcome of one lookup given the match result and the entry permission.
  function automatic lk_kind_t classify(input logic req, input logic matched,
                                        input logic is_wr, input logic wr_ok);
    if (!req)               return LK_IDLE;
    if (!matched)           return LK_MISS;
    if (is_wr && !wr_ok)    return LK_FAULT;
    return LK_HIT;
  endfunction

endpackage

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
  parameter int N  = 128,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic [IW-1:0] idx,
  output logic          found
);
  always_comb begin
    idx   = '0;
    found = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        idx   = IW'(i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int ENTRIES = 128,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8
) (
  input  logic [ENTRIES-1:0] ent_valid,
  input  logic [VPN_W-1:0]   ent_vpn  [ENTRIES],
  input  logic [ASID_W-1:0]  ent_asid [ENTRIES],
  input  logic [VPN_W-1:0]   key_vpn,
  input  logic [ASID_W-1:0]  key_asid,
  output logic [ENTRIES-1:0] match_vec
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_vec[g] = ent_valid[g] && (ent_vpn[g] == key_vpn)
                          && (ent_asid[g] == key_asid);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 128,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fill_req,
  input  logic [ENTRIES-1:0] valid_vec,
  input  logic [ENTRIES-1:0] use_vec,
  input  logic [ENTRIES-1:0] dup_vec,
  output logic [IDX_W-1:0]   victim_idx
);
  logic [IDX_W-1:0] dup_idx, free_idx, cold_idx;
  logic             dup_any, free_any, cold_any;

  tlb_first_set #(.N(ENTRIES), .IW(IDX_W)) u_dup
    (.vec(dup_vec), .idx(dup_idx), .found(dup_any));
  tlb_first_set #(.N(ENTRIES), .IW(IDX_W)) u_free
    (.vec(~valid_vec), .idx(free_idx), .found(free_any));
  tlb_first_set #(.N(ENTRIES), .IW(IDX_W)) u_cold
    (.vec(~use_vec), .idx(cold_idx), .found(cold_any));

  // Refill in place first, then a free slot, then a slot not recently used.
  always_comb begin
    if (dup_any)       victim_idx = dup_idx;
    else if (free_any) victim_idx = free_idx;
    else if (cold_any) victim_idx = cold_idx;
    else               victim_idx = '0;
  end

  AST_VICTIM_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !(|dup_vec) && !(&valid_vec)) |-> !valid_vec[victim_idx]); // R6
  AST_VICTIM_COLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req && !(|dup_vec) && (&valid_vec)) |-> !use_vec[victim_idx]); // R7
endmodule

// File: rtl/tlb_store.sv
module tlb_store #(
  parameter int ENTRIES = 128,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 24,
  parameter int ASID_W  = 8,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               acc_en,
  input  logic [IDX_W-1:0]   acc_idx,
  input  logic               acc_dirty,
  input  logic               fill_go,
  input  logic [IDX_W-1:0]   fill_idx,
  input  logic [VPN_W-1:0]   fill_vpn,
  input  logic [ASID_W-1:0]  fill_asid,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic               fill_wr_ok,
  input  logic               inv_all,
  input  logic               inv_asid_en,
  input  logic [ASID_W-1:0]  inv_asid,
  output logic [ENTRIES-1:0] valid_q,
  output logic [ENTRIES-1:0] use_q,
  output logic [ENTRIES-1:0] dirty_q,
  output logic [ENTRIES-1:0] wr_ok_q,
  output logic [VPN_W-1:0]   vpn_q  [ENTRIES],
  output logic [ASID_W-1:0]  asid_q [ENTRIES],
  output logic [PPN_W-1:0]   ppn_q  [ENTRIES]
);
  logic [ENTRIES-1:0] valid_n, use_n, dirty_n, use_pre;
  logic               use_wrap;

  always_comb begin
    valid_n = valid_q;
    use_n   = use_q;
    dirty_n = dirty_q;
    if (acc_en) begin
      use_n[acc_idx] = 1'b1;
      if (acc_dirty) dirty_n[acc_idx] = 1'b1;
    end
    if (inv_all) begin
      valid_n = '0;
      use_n   = '0;
      dirty_n = '0;
    end else if (inv_asid_en) begin
      for (int i = 0; i < ENTRIES; i++) begin
        if (asid_q[i] == inv_asid) begin
          valid_n[i] = 1'b0;
          use_n[i]   = 1'b0;
          dirty_n[i] = 1'b0;
        end
      end
    end
    if (fill_go) begin
      valid_n[fill_idx] = 1'b1;
      use_n[fill_idx]   = 1'b1;
      dirty_n[fill_idx] = 1'b0;
    end
    use_pre  = use_n;
    use_wrap = &use_pre;
    if (use_wrap) use_n = '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      use_q   <= '0;
      dirty_q <= '0;
    end else begin
      valid_q <= valid_n;
      use_q   <= use_n;
      dirty_q <= dirty_n;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_go) begin
      vpn_q[fill_idx]   <= fill_vpn;
      asid_q[fill_idx]  <= fill_asid;
      ppn_q[fill_idx]   <= fill_ppn;
      wr_ok_q[fill_idx] <= fill_wr_ok;
    end
  end

  AST_INV_ALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all |=> (valid_q == '0)); // R10
  AST_FILL_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_go |=> valid_q[$past(fill_idx)]); // R6
  AST_USE_NEVER_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    !(&use_q)); // R8
endmodule

// File: rtl/tlb_fa.sv
module tlb_fa #(
  parameter int ENTRIES = 128,
  parameter int VA_W    = 32,
  parameter int PA_W    = 36,
  parameter int PAGE_W  = 12,
  parameter int ASID_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     lk_valid,
  input  logic                     lk_write,
  input  logic [VA_W-1:0]          lk_vaddr,
  input  logic [ASID_W-1:0]        lk_asid,
  input  logic                     fill_en,
  input  logic [VA_W-PAGE_W-1:0]   fill_vpn,
  input  logic [ASID_W-1:0]        fill_asid,
  input  logic [PA_W-PAGE_W-1:0]   fill_ppn,
  input  logic                     fill_wr_ok,
  input  logic                     inv_all,
  input  logic                     inv_asid_en,
  input  logic [ASID_W-1:0]        inv_asid,
  output logic                     rsp_valid,
  output logic                     rsp_hit,
  output logic                     rsp_miss,
  output logic                     rsp_fault,
  output logic                     rsp_dirty,
  output logic [PA_W-1:0]          rsp_paddr
);
  import tlb_pkg::*;

  localparam int VPN_W = VA_W - PAGE_W;
  localparam int PPN_W = PA_W - PAGE_W;
  localparam int IDX_W = $clog2(ENTRIES);

  function automatic logic [PA_W-1:0] join_paddr(input logic [PPN_W-1:0] ppn,
                                                 input logic [VA_W-1:0] va);
    return {ppn, va[PAGE_W-1:0]};
  endfunction

  logic [ENTRIES-1:0] valid_q, use_q, dirty_q, wr_ok_q;
  logic [VPN_W-1:0]   vpn_q  [ENTRIES];
  logic [ASID_W-1:0]  asid_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q  [ENTRIES];

  logic [ENTRIES-1:0] lk_match, fill_match;
  logic [IDX_W-1:0]   hit_idx, victim_idx;
  logic               hit_any;
  logic               fill_go;
  logic               acc_en, acc_dirty;
  lk_kind_t           lk_kind;

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_lk (
    .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
    .key_vpn(lk_vaddr[VA_W-1:PAGE_W]), .key_asid(lk_asid),
    .match_vec(lk_match));

  tlb_cam #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_cam_fill (
    .ent_valid(valid_q), .ent_vpn(vpn_q), .ent_asid(asid_q),
    .key_vpn(fill_vpn), .key_asid(fill_asid),
    .match_vec(fill_match));

  tlb_first_set #(.N(ENTRIES), .IW(IDX_W)) u_hit_enc (
    .vec(lk_match), .idx(hit_idx), .found(hit_any));

  assign fill_go = fill_en && !inv_all && !inv_asid_en;

  tlb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
    .clk(clk), .rst_n(rst_n), .fill_req(fill_go),
    .valid_vec(valid_q), .use_vec(use_q), .dup_vec(fill_match),
    .victim_idx(victim_idx));

  assign lk_kind   = classify(lk_valid, hit_any, lk_write, wr_ok_q[hit_idx]);
  assign acc_en    = (lk_kind == LK_HIT) || (lk_kind == LK_FAULT);
  assign acc_dirty = (lk_kind == LK_HIT) && lk_write;

  tlb_store #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PPN_W(PPN_W),
              .ASID_W(ASID_W), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .acc_en(acc_en), .acc_idx(hit_idx), .acc_dirty(acc_dirty),
    .fill_go(fill_go), .fill_idx(victim_idx), .fill_vpn(fill_vpn),
    .fill_asid(fill_asid), .fill_ppn(fill_ppn), .fill_wr_ok(fill_wr_ok),
    .inv_all(inv_all), .inv_asid_en(inv_asid_en), .inv_asid(inv_asid),
    .valid_q(valid_q), .use_q(use_q), .dirty_q(dirty_q), .wr_ok_q(wr_ok_q),
    .vpn_q(vpn_q), .asid_q(asid_q), .ppn_q(ppn_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_miss  <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_dirty <= 1'b0;
      rsp_paddr <= '0;
    end else begin
      rsp_valid <= (lk_kind != LK_IDLE);
      rsp_hit   <= (lk_kind == LK_HIT);
      rsp_miss  <= (lk_kind == LK_MISS);
      rsp_fault <= (lk_kind == LK_FAULT);
      rsp_dirty <= (lk_kind == LK_HIT) && (dirty_q[hit_idx] || lk_write);
      rsp_paddr <= (lk_kind == LK_HIT) ? join_paddr(ppn_q[hit_idx], lk_vaddr) : '0;
    end
  end

  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    lk_valid |=> rsp_valid); // R2
  AST_RSP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_valid |=> !(rsp_valid || rsp_hit || rsp_miss || rsp_fault)); // R2
  AST_RSP_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($countones({rsp_hit, rsp_miss, rsp_fault}) == 1)); // R2
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_paddr == '0 && !rsp_dirty)); // R4
  AST_SINGLE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match) && $onehot0(fill_match)); // R9
  AST_WRITE_HIT_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_write) |=> (!rsp_hit || rsp_dirty)); // R5
endmodule

// File: tb/tlb_fa_tb.sv
module tlb_fa_tb;
  localparam int N      = 128;
  localparam int VA_W   = 32;
  localparam int PA_W   = 36;
  localparam int PAGE_W = 12;
  localparam int ASID_W = 8;
  localparam int VPN_W  = VA_W - PAGE_W;
  localparam int PPN_W  = PA_W - PAGE_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_valid = 0, lk_write = 0;
  logic [VA_W-1:0] lk_vaddr = '0;
  logic [ASID_W-1:0] lk_asid = '0;
  logic fill_en = 0, fill_wr_ok = 0;
  logic [VPN_W-1:0] fill_vpn = '0;
  logic [ASID_W-1:0] fill_asid = '0;
  logic [PPN_W-1:0] fill_ppn = '0;
  logic inv_all = 0, inv_asid_en = 0;
  logic [ASID_W-1:0] inv_asid = '0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_fault, rsp_dirty;
  logic [PA_W-1:0] rsp_paddr;

  always #4 clk = ~clk;

  tlb_fa u_dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  // bench model
  bit m_valid [N], m_use [N], m_dirty [N], m_wr [N];
  logic [VPN_W-1:0] m_vpn [N];
  logic [ASID_W-1:0] m_asid [N];
  logic [PPN_W-1:0] m_ppn [N];

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int find(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
    for (int i = 0; i < N; i++)
      if (m_valid[i] && m_vpn[i] == v && m_asid[i] == a) return i;
    return -1;
  endfunction

  function automatic int pick_slot(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a);
    int d = find(v, a);
    if (d >= 0) return d;
    for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
    for (int i = 0; i < N; i++) if (!m_use[i]) return i;
    return 0;
  endfunction

  function automatic logic [PA_W-1:0] exp_pa(input logic [PPN_W-1:0] p, input logic [VA_W-1:0] va);
    return {p, va[PAGE_W-1:0]};
  endfunction

  function automatic logic [VA_W-1:0] mk_va(input logic [VPN_W-1:0] v);
    return {v, 12'($urandom_range(4095))};
  endfunction

  // One cycle of stimulus; answer checked on the following negedge.
  task automatic step(input bit lk, input bit wr, input logic [VA_W-1:0] va,
                      input logic [ASID_W-1:0] la, input bit fe,
                      input logic [VPN_W-1:0] fv, input logic [ASID_W-1:0] fa,
                      input logic [PPN_W-1:0] fp, input bit fw, input bit ia,
                      input bit ie, input logic [ASID_W-1:0] ias, input string tag);
    int hi, slot;
    bit e_hit, e_miss, e_fault, e_dirty, all_use;
    logic [PA_W-1:0] e_pa;
    lk_valid = lk; lk_write = wr; lk_vaddr = va; lk_asid = la;
    fill_en = fe; fill_vpn = fv; fill_asid = fa; fill_ppn = fp; fill_wr_ok = fw;
    inv_all = ia; inv_asid_en = ie; inv_asid = ias;
    hi = find(va[VA_W-1:PAGE_W], la);
    e_miss = lk && hi < 0;
    e_fault = lk && hi >= 0 && wr && !m_wr[hi];
    e_hit = lk && hi >= 0 && !e_fault;
    e_dirty = e_hit && (m_dirty[hi] || wr);
    e_pa = e_hit ? exp_pa(m_ppn[hi], va) : '0;
    slot = pick_slot(fv, fa);
    @(negedge clk);
    check(rsp_valid == lk, {tag, " valid"}, 64'(rsp_valid), 64'(lk));
    check(rsp_hit == e_hit, {tag, " hit"}, 64'(rsp_hit), 64'(e_hit));
    check(rsp_miss == e_miss, {tag, " miss"}, 64'(rsp_miss), 64'(e_miss));
    check(rsp_fault == e_fault, {tag, " fault"}, 64'(rsp_fault), 64'(e_fault));
    check(rsp_dirty == e_dirty, {tag, " dirty"}, 64'(rsp_dirty), 64'(e_dirty));
    check(rsp_paddr == e_pa, {tag, " paddr"}, 64'(rsp_paddr), 64'(e_pa));
    // model update: access, invalidate, fill, use wrap
    if (e_hit || e_fault) begin
      m_use[hi] = 1;
      if (e_hit && wr) m_dirty[hi] = 1;
    end
    for (int i = 0; i < N; i++)
      if (ia || (ie && m_asid[i] == ias)) begin
        m_valid[i] = 0; m_use[i] = 0; m_dirty[i] = 0;
      end
    if (fe && !ia && !ie) begin
      m_valid[slot] = 1; m_use[slot] = 1; m_dirty[slot] = 0;
      m_vpn[slot] = fv; m_asid[slot] = fa; m_ppn[slot] = fp; m_wr[slot] = fw;
    end
    all_use = 1;
    for (int i = 0; i < N; i++) all_use &= m_use[i];
    if (all_use) for (int i = 0; i < N; i++) m_use[i] = 0;
    lk_valid = 0; fill_en = 0; inv_all = 0; inv_asid_en = 0; lk_write = 0;
  endtask

  task automatic look(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input bit wr, input string tag);
    step(1, wr, mk_va(v), a, 0, '0, '0, '0, 0, 0, 0, '0, tag);
  endtask

  task automatic fill(input logic [VPN_W-1:0] v, input logic [ASID_W-1:0] a,
                      input logic [PPN_W-1:0] p, input bit w, input string tag);
    step(0, 0, '0, '0, 1, v, a, p, w, 0, 0, '0, tag);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    int ev;
    logic [VPN_W-1:0] ev_vpn;
    void'($urandom(32'd1234));
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 0; m_use[i] = 0; m_dirty[i] = 0; m_wr[i] = 0;
      m_vpn[i] = '0; m_asid[i] = '0; m_ppn[i] = '0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    check(rsp_valid == 0, "R2 reset quiet", 64'(rsp_valid), 0);
    look(20'h5, 8'd1, 0, "R1 empty miss");
    // fill every slot; the last fill wraps the use bits (R8)
    for (int i = 0; i < N; i++)
      fill(VPN_W'(i * 3 + 7), 8'd1, PPN_W'(i * 17 + 1000), i[0], "R6 fill");
    look(VPN_W'(7), 8'd1, 0, "R1 hit slot0");
    look(VPN_W'(5 * 3 + 7), 8'd1, 0, "R5 read clean");
    look(VPN_W'(5 * 3 + 7), 8'd1, 1, "R5 write dirty");
    look(VPN_W'(5 * 3 + 7), 8'd1, 0, "R5 dirty stays");
    look(VPN_W'(4 * 3 + 7), 8'd1, 1, "R4 write fault");
    look(VPN_W'(4 * 3 + 7), 8'd1, 0, "R4 read ok");
    look(VPN_W'(2 * 3 + 7), 8'd2, 0, "R3 other asid");
    // replacement: lowest slot with clear use (slot1)
    ev = pick_slot(20'd5000, 8'd1);
    ev_vpn = m_vpn[ev];
    check(ev == 1, "R7 victim slot", 64'(ev), 1);
    fill(20'd5000, 8'd1, 24'hABCDE, 1, "R7 fill full");
    look(ev_vpn, 8'd1, 0, "R8 evicted misses");
    look(VPN_W'(7), 8'd1, 0, "R7 used kept");
    look(20'd5000, 8'd1, 1, "R7 new hit");
    // refill in place
    fill(20'd5000, 8'd1, 24'h13579, 0, "R9 refill");
    look(20'd5000, 8'd1, 0, "R9 new ppn clean");
    look(20'd5000, 8'd1, 1, "R9 now read-only");
    // per-identifier invalidation then hole reuse
    fill(20'd9000, 8'd2, 24'h222, 1, "R11 fill other");
    step(0, 0, '0, '0, 0, '0, '0, '0, 0, 0, 1, 8'd2, "R11 inv asid");
    look(20'd9000, 8'd2, 0, "R11 gone");
    look(VPN_W'(7), 8'd1, 0, "R11 others kept");
    fill(20'd9001, 8'd3, 24'h333, 1, "R6 hole reuse");
    look(VPN_W'(7), 8'd1, 0, "R6 nothing evicted");
    look(20'd9001, 8'd3, 0, "R6 hole hit");
    // fill dropped during invalidation
    step(0, 0, '0, '0, 1, 20'd9100, 8'd4, 24'h444, 1, 0, 1, 8'd9, "R12 fill drop");
    look(20'd9100, 8'd4, 0, "R12 dropped miss");
    // lookup and fill of the same page in one cycle
    step(1, 0, {20'd9200, 12'h0AB}, 8'd4, 1, 20'd9200, 8'd4, 24'h555, 1, 0, 0, '0,
         "R13 same cycle");
    look(20'd9200, 8'd4, 0, "R13 later hit");
    // lookup answered before same-cycle invalidate
    step(1, 0, {20'd9200, 12'h1}, 8'd4, 0, '0, '0, '0, 0, 1, 0, '0, "R13 before inv");
    look(VPN_W'(7), 8'd1, 0, "R10 all cleared");
    // random phase
    for (int k = 0; k < 4000; k++) begin
      int op = $urandom_range(99);
      logic [VPN_W-1:0] v = VPN_W'($urandom_range(199));
      logic [ASID_W-1:0] a = ASID_W'($urandom_range(3));
      if (op < 45) look(v, a, 1'($urandom_range(1)), "R1 rnd look");
      else if (op < 90) fill(v, a, PPN_W'($urandom), 1'($urandom_range(1)), "R7 rnd fill");
      else if (op < 97)
        step(1, 1'($urandom_range(1)), mk_va(v), a, 1, VPN_W'($urandom_range(199)),
             ASID_W'($urandom_range(3)), PPN_W'($urandom), 1, 0, 0, '0, "R13 rnd both");
      else if (op < 99) step(0, 0, '0, '0, 0, '0, '0, '0, 0, 0, 1, a, "R11 rnd inv");
      else step(0, 0, '0, '0, 0, '0, '0, '0, 0, 1, 0, '0, "R10 rnd inv all");
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule